// File: doc/BRIEF.md
# ChaCha Permutation Round Engine

This block applies the twenty-round ChaCha core permutation to a state of sixteen 32-bit words. The state arrives as one 512-bit vector, with word i in bits [32*i+31 : 32*i]. It is captured by a start strobe and then transformed in place by an iterative datapath. There are ten double rounds. Each double round is a pass over the four columns followed by a pass over the four diagonals.

The quarter-round is cut into its four add/xor/rotate steps, and the engine performs exactly one of them per clock. A permutation therefore takes 320 step cycles. The caller pulses start while the engine is idle, waits for the one-cycle done flag, and reads the permuted state. That state stays on the output until the next accepted start. A step counter is brought out so a test can see how far the sequence has progressed.

Key and nonce packing, the feed-forward addition of the input state and the keystream XOR all belong to the surrounding logic.

Top module: `chacha_perm_engine`

## Requirements
- R1: While reset is held low and after its release, busy and done read 0, the step counter reads 0 and the state output reads all zeros.
- R2: A start pulse seen at a clock edge while idle captures loadState into the state. From the next cycle the state output equals that vector, busy is 1 and the step counter is 0.
- R3: A quarter-round on words (a,b,c,d) runs four steps in this order: a=a+b then d=rotl(d^a,16); c=c+d then b=rotl(b^c,12); a=a+b then d=rotl(d^a,8); c=c+d then b=rotl(b^c,7). All sums are modulo 2^32. Each step updates exactly its two words in one clock.
- R4: The column pass works on word tuples (0,4,8,12), (1,5,9,13), (2,6,10,14), (3,7,11,15), in that order.
- R5: The diagonal pass works on word tuples (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14), in that order, after the column pass of the same double round.
- R6: The rotate amount follows the step position within each quarter-round, cycling 16, 12, 8, 7 without interruption across the whole sequence.
- R7: Exactly ten double rounds run, so busy stays high for exactly 320 cycles after the capture edge.
- R8: Done is high for exactly one cycle. That is the first cycle in which the final state is on the output, and busy is already low in it.
- R9: A start pulse while busy has no effect. The step sequence, the step counter and the state output continue as if it were absent.
- R10: When no permutation is running and no start is given, the state output holds its value whatever loadState does.
- R11: The step counter reads the number of steps completed since the last capture, from 0 up to 320, and holds 320 until the next capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Start request; accepted only while idle |
| loadState | input | 512 | Input state, word i at bits 32*i+31..32*i |
| busy | output | 1 | High while the permutation steps are running |
| donePulse | output | 1 | One-cycle flag marking the finished state |
| stateOut | output | 512 | Current state, same word layout as loadState |
| stepCount | output | 9 | Steps completed since the last capture |

## Verification
Several properties are checked in every cycle:
- done lasts one cycle and coincides with a full step count and busy low;
- a start while busy leaves busy set and lets the counter advance by exactly one;
- a capture places loadState on the output;
- the state does not move while nothing is strobed.

Assertions cannot see whether the arithmetic, the tuple order and the rotate schedule are correct. Only the bench can show this, by comparing the whole state every clock against a behavioural stepping model. That comparison covers a published quarter-round vector, the all-zero state, random states, start pulses injected mid-run and a restart in the done cycle.

// File: rtl/chacha_pkg.sv
package chacha_pkg;

  // Words per state and bits per word
  parameter int WORD_W    = 32;
  parameter int NUM_WORDS = 16;
  // Fixed by the permutation: four steps per quarter-round, eight quarter-rounds per double round
  parameter int PHASES    = 4;
  parameter int GROUPS    = 8;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic       capture;   // load the input state this edge
    logic       doStep;    // perform one add/xor/rotate step this edge
    logic [2:0] groupSel;  // 0..3 column tuples, 4..7 diagonal tuples
    logic [1:0] phaseSel;  // step position inside the quarter-round
  } stepCtrl_t;

endpackage

// File: rtl/chacha_perm_ctrl.sv
module chacha_perm_ctrl
  import chacha_pkg::*;
#(
  parameter int DOUBLE_ROUNDS = 10,
  localparam int TOTAL_STEPS  = DOUBLE_ROUNDS * GROUPS * PHASES,
  localparam int CNT_W        = $clog2(TOTAL_STEPS + 1),
  localparam int RND_W        = (DOUBLE_ROUNDS > 1) ? $clog2(DOUBLE_ROUNDS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  output stepCtrl_t        ctrl,
  output logic             busy,
  output logic             donePulse,
  output logic [CNT_W-1:0] stepCount
);

  logic             busyQ;
  logic             doneQ;
  logic [1:0]       phaseQ;
  logic [2:0]       groupQ;
  logic [RND_W-1:0] roundQ;
  logic [CNT_W-1:0] stepCntQ;
  logic             lastStep;
  logic             accept;

  always_comb begin
    accept   = !busyQ && startPulse;
    lastStep = busyQ && (phaseQ == 2'd3) && (groupQ == 3'd7) &&
               (roundQ == RND_W'(DOUBLE_ROUNDS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      doneQ    <= 1'b0;
      phaseQ   <= '0;
      groupQ   <= '0;
      roundQ   <= '0;
      stepCntQ <= '0;
    end else begin
      doneQ <= lastStep;
      if (accept) begin
        busyQ    <= 1'b1;
        phaseQ   <= '0;
        groupQ   <= '0;
        roundQ   <= '0;
        stepCntQ <= '0;
      end else if (busyQ) begin
        stepCntQ <= stepCntQ + CNT_W'(1);
        phaseQ   <= phaseQ + 2'd1;
        if (phaseQ == 2'd3) begin
          groupQ <= groupQ + 3'd1;
          if (groupQ == 3'd7) begin
            roundQ <= roundQ + RND_W'(1);
          end
        end
        if (lastStep) begin
          busyQ <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    ctrl.capture  = accept;
    ctrl.doStep   = busyQ;
    ctrl.groupSel = groupQ;
    ctrl.phaseSel = phaseQ;
  end

  assign busy      = busyQ;
  assign donePulse = doneQ;
  assign stepCount = stepCntQ;

  // R8: the finish flag never lasts two cycles
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R7 / R11: the finish flag comes with a full count and an idle engine
  assert_done_full_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (stepCount == CNT_W'(TOTAL_STEPS)) && !busy);

  // R9: a start while running neither stops nor restarts the sequence
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && !lastStep) |=> busy && (stepCount == $past(stepCount) + CNT_W'(1)));

endmodule

// File: rtl/chacha_perm_datapath.sv
module chacha_perm_datapath
  import chacha_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = NUM_WORDS,
  localparam int IDX_W   = $clog2(N),
  localparam int STATE_W = W * N,
  localparam int ROT_P0  = 16,
  localparam int ROT_P1  = 12,
  localparam int ROT_P2  = 8,
  localparam int ROT_P3  = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  stepCtrl_t          ctrl,
  input  logic [STATE_W-1:0] loadState,
  output logic [STATE_W-1:0] stateOut
);

  logic [W-1:0]     wordQ [N];
  logic [IDX_W-1:0] sumIdx;
  logic [IDX_W-1:0] addIdx;
  logic [IDX_W-1:0] mixIdx;
  logic [W-1:0]     sumVal;
  logic [W-1:0]     mixVal;
  logic [W-1:0]     rotVal;

  // Word index of a lane (a=0,b=1,c=2,d=3) for a tuple group: lane selects the row,
  // the column is shifted by the lane number on diagonal groups
  function automatic logic [IDX_W-1:0] laneIdx(input logic [2:0] grp, input logic [1:0] lane);
    logic [1:0] col;
    col = grp[1:0] + (grp[2] ? lane : 2'd0);
    return IDX_W'({lane, col});
  endfunction

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int n);
    return (x << n) | (x >> (W - n));
  endfunction

  // Even steps: a += b, d mixed. Odd steps: c += d, b mixed.
  always_comb begin
    if (!ctrl.phaseSel[0]) begin
      sumIdx = laneIdx(ctrl.groupSel, 2'd0);
      addIdx = laneIdx(ctrl.groupSel, 2'd1);
      mixIdx = laneIdx(ctrl.groupSel, 2'd3);
    end else begin
      sumIdx = laneIdx(ctrl.groupSel, 2'd2);
      addIdx = laneIdx(ctrl.groupSel, 2'd3);
      mixIdx = laneIdx(ctrl.groupSel, 2'd1);
    end
    sumVal = wordQ[sumIdx] + wordQ[addIdx];
    mixVal = wordQ[mixIdx] ^ sumVal;
    case (ctrl.phaseSel)
      2'd0:    rotVal = rotl(mixVal, ROT_P0);
      2'd1:    rotVal = rotl(mixVal, ROT_P1);
      2'd2:    rotVal = rotl(mixVal, ROT_P2);
      default: rotVal = rotl(mixVal, ROT_P3);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) wordQ[i] <= '0;
    end else if (ctrl.capture) begin
      for (int i = 0; i < N; i++) wordQ[i] <= loadState[i*W +: W];
    end else if (ctrl.doStep) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == sumIdx)      wordQ[i] <= sumVal;
        else if (IDX_W'(i) == mixIdx) wordQ[i] <= rotVal;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) stateOut[i*W +: W] = wordQ[i];
  end

  // R2: an accepted start places the input vector on the output
  assert_capture_loads_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> stateOut == $past(loadState));

  // R10: with no strobe from the sequencer the state does not move
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.capture && !ctrl.doStep) |=> $stable(stateOut));

endmodule

// File: rtl/chacha_perm_engine.sv
module chacha_perm_engine
  import chacha_pkg::*;
#(
  parameter int DOUBLE_ROUNDS = 10,
  localparam int STATE_W      = WORD_W * NUM_WORDS,
  localparam int CNT_W        = $clog2(DOUBLE_ROUNDS * GROUPS * PHASES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [STATE_W-1:0] loadState,
  output logic               busy,
  output logic               donePulse,
  output logic [STATE_W-1:0] stateOut,
  output logic [CNT_W-1:0]   stepCount
);

  stepCtrl_t ctrl;

  chacha_perm_ctrl #(
    .DOUBLE_ROUNDS(DOUBLE_ROUNDS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .ctrl      (ctrl),
    .busy      (busy),
    .donePulse (donePulse),
    .stepCount (stepCount)
  );

  chacha_perm_datapath #(
    .W(WORD_W),
    .N(NUM_WORDS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .loadState(loadState),
    .stateOut (stateOut)
  );

endmodule

// File: tb/tb_chacha_perm_engine.sv
`timescale 1ns/1ps
module tb_chacha_perm_engine;

  logic         clk = 1'b0;
  logic         rstN;
  logic         startPulse;
  logic [511:0] loadState;
  logic         busy;
  logic         donePulse;
  logic [511:0] stateOut;
  logic [8:0]   stepCount;

  always #2 clk = ~clk;

  chacha_perm_engine dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .loadState(loadState),
    .busy(busy), .donePulse(donePulse), .stateOut(stateOut), .stepCount(stepCount)
  );

  int checks = 0;
  int errors = 0;
  int busyCycles = 0;

  // Behavioural model state
  bit [31:0] mWord [16];
  bit        mBusy;
  bit        mDone;
  int        mSteps;

  // R4 column tuples then R5 diagonal tuples, in pass order
  int tuples [8][4] = '{
    '{0, 4, 8, 12}, '{1, 5, 9, 13}, '{2, 6, 10, 14}, '{3, 7, 11, 15},
    '{0, 5, 10, 15}, '{1, 6, 11, 12}, '{2, 7, 8, 13}, '{3, 4, 9, 14}};
  // R6 rotate schedule
  int rots [4] = '{16, 12, 8, 7};

  function automatic bit [31:0] rotl32(bit [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic bit [511:0] modelVec();
    bit [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = mWord[i];
    return v;
  endfunction

  // Advance the model by one clock edge given the inputs driven for it
  task automatic modelAdvance(bit st, bit [511:0] ld);
    int ph, grp, a, b, c, d;
    if (!mBusy && st) begin
      for (int i = 0; i < 16; i++) mWord[i] = ld[i*32 +: 32];
      mBusy = 1; mSteps = 0; mDone = 0;
    end else if (mBusy) begin
      ph  = mSteps % 4;
      grp = (mSteps / 4) % 8;
      a = tuples[grp][0]; b = tuples[grp][1]; c = tuples[grp][2]; d = tuples[grp][3];
      if (ph % 2 == 0) begin
        mWord[a] = mWord[a] + mWord[b];
        mWord[d] = rotl32(mWord[d] ^ mWord[a], rots[ph]);
      end else begin
        mWord[c] = mWord[c] + mWord[d];
        mWord[b] = rotl32(mWord[b] ^ mWord[c], rots[ph]);
      end
      mSteps++;
      if (mSteps == 320) begin mBusy = 0; mDone = 1; end
      else mDone = 0;
    end else begin
      mDone = 0;
    end
  endtask

  task automatic checkVal(string req, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    checkVal("R3", "state", stateOut, modelVec());
    checkVal("R7", "busy", 512'(busy), 512'(mBusy));
    checkVal("R8", "done", 512'(donePulse), 512'(mDone));
    checkVal("R11", "stepCount", 512'(stepCount), 512'(mSteps));
  endtask

  // Called at a falling edge: compare, drive, advance model, move to next falling edge
  task automatic cycle(bit st, bit [511:0] ld);
    compareAll();
    if (busy === 1'b1) busyCycles++;
    startPulse = st;
    loadState  = ld;
    modelAdvance(st, ld);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit [511:0] randState();
    bit [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic runOut();
    while (mBusy || mDone) cycle(0, randState());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [511:0] v;
    bit [511:0] held;
    rstN = 1'b0;
    startPulse = 1'b0;
    loadState = '0;
    for (int i = 0; i < 16; i++) mWord[i] = 0;
    mBusy = 0; mDone = 0; mSteps = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    checkVal("R1", "busy in reset", 512'(busy), 512'(0));
    checkVal("R1", "state in reset", stateOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1", "done after reset", 512'(donePulse), 512'(0));
    checkVal("R1", "count after reset", 512'(stepCount), 512'(0));
    cycle(0, '0);

    // Published quarter-round vector on column 0 (R3, R4)
    v = '0;
    v[0*32 +: 32]  = 32'h11111111;
    v[4*32 +: 32]  = 32'h01020304;
    v[8*32 +: 32]  = 32'h9b8d6f43;
    v[12*32 +: 32] = 32'h01234567;
    cycle(1, v);
    checkVal("R2", "captured state", stateOut, v);
    checkVal("R2", "busy after capture", 512'(busy), 512'(1));
    busyCycles = 0;
    repeat (4) cycle(0, '0);
    checkVal("R3", "qr word a", 512'(stateOut[0*32 +: 32]), 512'(32'hea2a92f4));
    checkVal("R3", "qr word b", 512'(stateOut[4*32 +: 32]), 512'(32'hcb1cf8ce));
    checkVal("R3", "qr word c", 512'(stateOut[8*32 +: 32]), 512'(32'h4581472e));
    checkVal("R3", "qr word d", 512'(stateOut[12*32 +: 32]), 512'(32'h5881c4bb));
    // End of first diagonal pass (R5, R6)
    repeat (28) cycle(0, '0);
    checkVal("R5", "state after diagonal pass", stateOut, modelVec());
    runOut();
    checkVal("R7", "busy cycle count", 512'(busyCycles), 512'(320));

    // All-zero state stays zero (R3)
    cycle(1, '0);
    runOut();
    checkVal("R3", "zero state result", stateOut, '0);

    // Random states with start pulses injected while busy (R9)
    for (int k = 0; k < 3; k++) begin
      cycle(1, randState());
      for (int s = 0; s < 320; s++) cycle((s % 37) == 5, randState());
      checkVal("R9", "steps unaffected by busy start", 512'(stepCount), 512'(320));
      runOut();
    end

    // Idle hold with changing input (R10)
    held = stateOut;
    for (int s = 0; s < 10; s++) cycle(0, randState());
    checkVal("R10", "idle state held", stateOut, held);

    // Restart in the done cycle
    cycle(1, randState());
    while (!mDone) cycle(0, '0);
    cycle(1, randState());
    checkVal("R2", "restart on done cycle busy", 512'(busy), 512'(1));
    runOut();
    checkVal("R11", "count holds at end", 512'(stepCount), 512'(320));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule